// File: doc/BRIEF.md
# Predicate Register File with Dual-Destination Compare

This block keeps a bank of one-bit predicate registers for a machine that gates every instruction's writeback with a qualifying predicate instead of branching around it. A compare port takes two integer operands and a condition code. It writes the outcome of the condition to one named predicate and the complement of that outcome to a second named predicate, so one compare sets up both arms of an if/else.

Each read port takes the qualifying-predicate index of an issuing instruction together with a valid flag. It returns a commit-enable that the writeback stage uses to keep or discard the instruction's result. Predicate 0 always reads as 1, so an instruction that names it always commits. Compare results are registered and become visible to the read ports one cycle after the compare.

Top module: `pred_file`

## Requirements
- R1: After a synchronous active-high reset, every predicate other than predicate 0 holds 0, so a valid read of any nonzero index yields commit 0 until a compare writes that index.
- R2: Predicate 0 always reads as 1, and a compare that names index 0 as either destination leaves it unchanged.
- R3: A compare with a defined condition writes its outcome to the predicate at `cmp_dst_t` and the inverse outcome to the predicate at `cmp_dst_f`. When the two indices differ, exactly one of the pair is 1 afterwards.
- R4: Condition codes on `cmp_op`: 0 = equal, 1 = not equal, 2 = a < b signed, 3 = a < b unsigned, 4 = a <= b signed, 5 = a <= b unsigned.
- R5: Condition codes 6 and 7 are undefined, and a compare carrying either of them changes no predicate.
- R6: When `cmp_dst_t` and `cmp_dst_f` name the same register, that register receives the true outcome.
- R7: A read in the same cycle as a compare that writes the read index returns the old value. The new value is returned from the next cycle on.
- R8: `rd_commit[k]` is 1 exactly when `rd_valid[k]` is 1 and the predicate selected by read index slot k (bits k*6 to k*6+5 of `rd_qp`) is 1. With `rd_valid[k]` at 0 the output is 0.
- R9: With `cmp_valid` at 0, no predicate changes, whatever the other compare inputs are.
- R10: A predicate that a compare does not name keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare request this cycle |
| cmp_op | input | 3 | Condition code (R4) |
| cmp_a | input | 32 | First operand |
| cmp_b | input | 32 | Second operand |
| cmp_dst_t | input | 6 | Index that receives the outcome |
| cmp_dst_f | input | 6 | Index that receives the inverse outcome |
| rd_valid | input | 2 | One issue-valid flag per read port |
| rd_qp | input | 12 | Qualifying-predicate index per read port, 6 bits each, port 0 in the low bits |
| rd_commit | output | 2 | Commit-enable per read port |

## Verification
A wrong bit in the bank is invisible until an instruction names that index. Then it shows up as a commit-enable of the wrong polarity on the same cycle as the read, which means one instruction's result is kept or thrown away wrongly. A mis-decoded condition or a swapped destination pair appears one cycle after the compare, on the first read of either destination. Corruption of an index that the compare did not name shows up only on a later read of that index. For that reason the bench compares every read port on every cycle against a full model of all predicates.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [2:0] {
        COND_EQ   = 3'd0,
        COND_NE   = 3'd1,
        COND_LT   = 3'd2,
        COND_LTU  = 3'd3,
        COND_LE   = 3'd4,
        COND_LEU  = 3'd5,
        COND_RSV6 = 3'd6,
        COND_RSV7 = 3'd7
    } cond_e;

    // Width-independent relation of two operands.
    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    // Outcome of a compare: whether it writes, and the truth value.
    typedef struct packed {
        logic fire;
        logic truth;
    } cmp_result_t;

    function automatic cmp_result_t resolve_cond(input cond_e c, input cmp_flags_t f);
        cmp_result_t r;
        r.fire  = 1'b1;
        r.truth = 1'b0;
        case (c)
            COND_EQ:  r.truth = f.eq;
            COND_NE:  r.truth = ~f.eq;
            COND_LT:  r.truth = f.lt_s;
            COND_LTU: r.truth = f.lt_u;
            COND_LE:  r.truth = f.lt_s | f.eq;
            COND_LEU: r.truth = f.lt_u | f.eq;
            default:  r.fire  = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pred_cmp_flags.sv
module pred_cmp_flags
    import pred_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output cmp_flags_t        flags
);
    always_comb begin
        flags.eq   = (opnd_a == opnd_b);
        flags.lt_s = ($signed(opnd_a) < $signed(opnd_b));
        flags.lt_u = (opnd_a < opnd_b);
    end
endmodule

// File: rtl/pred_wr_ctrl.sv
module pred_wr_ctrl
    import pred_pkg::*;
#(
    parameter int NUM_PREDS = 64,
    localparam int IDX_W = $clog2(NUM_PREDS)
) (
    input  logic                 req_valid,
    input  cond_e                cond,
    input  cmp_flags_t           flags,
    input  logic [IDX_W-1:0]     dst_t,
    input  logic [IDX_W-1:0]     dst_f,
    output logic [NUM_PREDS-1:1] wr_en,
    output logic [NUM_PREDS-1:1] wr_data
);
    cmp_result_t res;

    always_comb res = resolve_cond(cond, flags);

    for (genvar i = 1; i < NUM_PREDS; i++) begin : g_slot
        logic hit_t;
        logic hit_f;
        always_comb begin
            hit_t      = (dst_t == IDX_W'(i));
            hit_f      = (dst_f == IDX_W'(i));
            wr_en[i]   = req_valid & res.fire & (hit_t | hit_f);
            // true destination takes priority over the inverse
            wr_data[i] = hit_t ? res.truth : ~res.truth;
        end
    end
endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
    parameter int NUM_PREDS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PREDS-1:1] wr_en,
    input  logic [NUM_PREDS-1:1] wr_data,
    output logic [NUM_PREDS-1:0] state
);
    assign state[0] = 1'b1;

    for (genvar i = 1; i < NUM_PREDS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                state[i] <= 1'b0;
            else if (wr_en[i])
                state[i] <= wr_data[i];
        end
    end
endmodule

// File: rtl/pred_rd_port.sv
module pred_rd_port #(
    parameter int NUM_PREDS = 64,
    localparam int IDX_W = $clog2(NUM_PREDS)
) (
    input  logic [NUM_PREDS-1:0] state,
    input  logic                 issue_valid,
    input  logic [IDX_W-1:0]     qp_idx,
    output logic                 commit
);
    assign commit = issue_valid & state[qp_idx];
endmodule

// File: rtl/pred_file.sv
module pred_file
    import pred_pkg::*;
#(
    parameter int NUM_PREDS = 64,
    parameter int OPND_W    = 32,
    parameter int NUM_RD    = 2,
    localparam int IDX_W = $clog2(NUM_PREDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmp_valid,
    input  logic [2:0]              cmp_op,
    input  logic [OPND_W-1:0]       cmp_a,
    input  logic [OPND_W-1:0]       cmp_b,
    input  logic [IDX_W-1:0]        cmp_dst_t,
    input  logic [IDX_W-1:0]        cmp_dst_f,
    input  logic [NUM_RD-1:0]       rd_valid,
    input  logic [NUM_RD*IDX_W-1:0] rd_qp,
    output logic [NUM_RD-1:0]       rd_commit
);
    cmp_flags_t           flags;
    logic [NUM_PREDS-1:1] wr_en;
    logic [NUM_PREDS-1:1] wr_data;
    logic [NUM_PREDS-1:0] state;

    pred_cmp_flags #(.OPND_W(OPND_W)) i_flags (
        .opnd_a (cmp_a),
        .opnd_b (cmp_b),
        .flags  (flags)
    );

    pred_wr_ctrl #(.NUM_PREDS(NUM_PREDS)) i_wr (
        .req_valid (cmp_valid),
        .cond      (cond_e'(cmp_op)),
        .flags     (flags),
        .dst_t     (cmp_dst_t),
        .dst_f     (cmp_dst_f),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    pred_bank #(.NUM_PREDS(NUM_PREDS)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .state   (state)
    );

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        pred_rd_port #(.NUM_PREDS(NUM_PREDS)) i_rd (
            .state       (state),
            .issue_valid (rd_valid[k]),
            .qp_idx      (rd_qp[k*IDX_W +: IDX_W]),
            .commit      (rd_commit[k])
        );
    end
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
    parameter int NUM_PREDS = 64,
    parameter int OPND_W    = 32,
    parameter int NUM_RD    = 2,
    localparam int IDX_W = $clog2(NUM_PREDS)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cmp_valid,
    input logic [2:0]              cmp_op,
    input logic [OPND_W-1:0]       cmp_a,
    input logic [OPND_W-1:0]       cmp_b,
    input logic [IDX_W-1:0]        cmp_dst_t,
    input logic [IDX_W-1:0]        cmp_dst_f,
    input logic [NUM_RD-1:0]       rd_valid,
    input logic [NUM_RD*IDX_W-1:0] rd_qp,
    input logic [NUM_RD-1:0]       rd_commit
);
    logic [IDX_W-1:0] qp0;
    assign qp0 = rd_qp[IDX_W-1:0];

    // R8
    idle_port_low_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid[0] |-> !rd_commit[0]);

    // R2
    p0_always_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid[0] && qp0 == '0) |-> rd_commit[0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_valid[0] && qp0 != '0) |-> !rd_commit[0]);

    // R6
    same_dst_true_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cmp_valid) && $past(cmp_op) == 3'd0 && $past(cmp_dst_t) == $past(cmp_dst_f)
         && $past(cmp_dst_t) != '0 && rd_valid[0] && qp0 == $past(cmp_dst_t))
        |-> rd_commit[0] == ($past(cmp_a) == $past(cmp_b)));

    // R9
    idle_cmp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmp_valid) && !$past(rst) && $stable(rd_qp) && rd_valid[0] && $past(rd_valid[0]))
        |-> $stable(rd_commit[0]));

    if (NUM_RD >= 2) begin : g_pair
        logic [IDX_W-1:0] qp1;
        assign qp1 = rd_qp[2*IDX_W-1:IDX_W];
        // R3
        pair_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(cmp_valid) && $past(cmp_op) < 3'd6 && $past(cmp_dst_t) != $past(cmp_dst_f)
             && $past(cmp_dst_t) != '0 && $past(cmp_dst_f) != '0
             && rd_valid[0] && rd_valid[1]
             && qp0 == $past(cmp_dst_t) && qp1 == $past(cmp_dst_f))
            |-> (rd_commit[0] != rd_commit[1]));
    end
endmodule

bind pred_file pred_file_chk #(
    .NUM_PREDS (NUM_PREDS),
    .OPND_W    (OPND_W),
    .NUM_RD    (NUM_RD)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .cmp_op    (cmp_op),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_dst_t (cmp_dst_t),
    .cmp_dst_f (cmp_dst_f),
    .rd_valid  (rd_valid),
    .rd_qp     (rd_qp),
    .rd_commit (rd_commit)
);

// File: tb/test_pred_file.sv
`timescale 1ns/1ps
module test_pred_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_op = '0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [5:0]  cmp_dst_t = '0;
    logic [5:0]  cmp_dst_f = '0;
    logic [1:0]  rd_valid = '0;
    logic [11:0] rd_qp = '0;
    logic [1:0]  rd_commit;

    int total = 0;
    int bad = 0;
    logic model [64];

    always #2.5 clk = ~clk;

    pred_file i_pred_file (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .rd_valid(rd_valid), .rd_qp(rd_qp), .rd_commit(rd_commit)
    );

    // Condition evaluation from R4 / R5
    function automatic logic cond_defined(input logic [2:0] op);
        return op < 3'd6;
    endfunction

    function automatic logic cond_truth(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) < $signed(b);
            3'd3: return a < b;
            3'd4: return $signed(a) <= $signed(b);
            3'd5: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_port(input int k, input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s port%0d: got=%b expected=%b", tag, k, got, exp);
        end
    endtask

    // One cycle: drive, check reads against model, then apply the compare to the model.
    task automatic cycle(input logic v, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [5:0] dt, input logic [5:0] df,
                         input logic rv0, input logic [5:0] q0,
                         input logic rv1, input logic [5:0] q1, input string tag);
        logic t;
        @(negedge clk);
        cmp_valid = v; cmp_op = op; cmp_a = a; cmp_b = b;
        cmp_dst_t = dt; cmp_dst_f = df;
        rd_valid = {rv1, rv0}; rd_qp = {q1, q0};
        #1;
        check_port(0, rd_commit[0], rv0 & model[q0], tag);
        check_port(1, rd_commit[1], rv1 & model[q1], tag);
        @(posedge clk);
        if (v && cond_defined(op)) begin
            t = cond_truth(op, a, b);
            if (df != 6'd0) model[df] = ~t;
            if (dt != 6'd0) model[dt] = t;
        end
    endtask

    task automatic rd2(input logic [5:0] q0, input logic [5:0] q1, input string tag);
        cycle(1'b0, 3'd0, 32'd0, 32'd0, 6'd0, 6'd0, 1'b1, q0, 1'b1, q1, tag);
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) model[i] = (i == 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of every index
        for (int i = 0; i < 32; i++) rd2(6'(2*i), 6'(2*i+1), "R1");

        // R2: writes aimed at predicate 0 are dropped
        cycle(1'b1, 3'd1, 32'd7, 32'd7, 6'd0, 6'd3, 1'b0, 6'd0, 1'b0, 6'd0, "R2");
        rd2(6'd0, 6'd3, "R2");
        cycle(1'b1, 3'd0, 32'd7, 32'd7, 6'd4, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0, "R2");
        rd2(6'd0, 6'd4, "R2");

        // R3: complementary pair, both polarities
        cycle(1'b1, 3'd0, 32'd5, 32'd5, 6'd10, 6'd11, 1'b0, 6'd0, 1'b0, 6'd0, "R3");
        rd2(6'd10, 6'd11, "R3");
        cycle(1'b1, 3'd0, 32'd5, 32'd6, 6'd10, 6'd11, 1'b0, 6'd0, 1'b0, 6'd0, "R3");
        rd2(6'd10, 6'd11, "R3");

        // R4: each condition with signed/unsigned-sensitive and equal operands
        for (int op = 0; op < 6; op++) begin
            cycle(1'b1, 3'(op), 32'hFFFF_FFFF, 32'd1, 6'(20+op), 6'(30+op), 1'b0, 6'd0, 1'b0, 6'd0, "R4");
            rd2(6'(20+op), 6'(30+op), "R4");
            cycle(1'b1, 3'(op), 32'd9, 32'd9, 6'(20+op), 6'(30+op), 1'b0, 6'd0, 1'b0, 6'd0, "R4");
            rd2(6'(20+op), 6'(30+op), "R4");
            cycle(1'b1, 3'(op), 32'd2, 32'h8000_0000, 6'(20+op), 6'(30+op), 1'b0, 6'd0, 1'b0, 6'd0, "R4");
            rd2(6'(20+op), 6'(30+op), "R4");
        end

        // R5: undefined codes change nothing
        cycle(1'b1, 3'd0, 32'd1, 32'd1, 6'd40, 6'd41, 1'b0, 6'd0, 1'b0, 6'd0, "R5");
        cycle(1'b1, 3'd6, 32'd1, 32'd1, 6'd41, 6'd40, 1'b0, 6'd0, 1'b0, 6'd0, "R5");
        rd2(6'd40, 6'd41, "R5");
        cycle(1'b1, 3'd7, 32'd1, 32'd2, 6'd41, 6'd40, 1'b0, 6'd0, 1'b0, 6'd0, "R5");
        rd2(6'd40, 6'd41, "R5");

        // R6: same index on both destinations
        cycle(1'b1, 3'd0, 32'd3, 32'd3, 6'd50, 6'd50, 1'b0, 6'd0, 1'b0, 6'd0, "R6");
        rd2(6'd50, 6'd50, "R6");
        cycle(1'b1, 3'd1, 32'd3, 32'd3, 6'd50, 6'd50, 1'b0, 6'd0, 1'b0, 6'd0, "R6");
        rd2(6'd50, 6'd50, "R6");

        // R7: no same-cycle bypass
        cycle(1'b1, 3'd0, 32'd8, 32'd8, 6'd12, 6'd13, 1'b1, 6'd12, 1'b1, 6'd13, "R7");
        rd2(6'd12, 6'd13, "R7");

        // R8: invalid issue never commits, even for predicate 0
        cycle(1'b0, 3'd0, 32'd0, 32'd0, 6'd0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd12, "R8");

        // R9: compare inputs without valid
        cycle(1'b0, 3'd0, 32'd4, 32'd4, 6'd13, 6'd12, 1'b0, 6'd0, 1'b0, 6'd0, "R9");
        rd2(6'd12, 6'd13, "R9");

        // R10: random traffic, every read checked against the full model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            cycle(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), ra, rb,
                  6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)),
                  1'($urandom_range(0, 4) != 0), 6'($urandom_range(0, 63)),
                  1'($urandom_range(0, 4) != 0), 6'($urandom_range(0, 63)), "R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule